// File: doc/BRIEF.md
# Receiver Chip-Mode Sequencer with Serial Configuration Port

This block accepts 24-bit write frames on a serial peripheral port and uses them to steer the operating mode of a radio receiver. It also keeps the receiver's configuration bytes in a small RAM. After reset the machine runs an oscillator startup period. It then runs an initialisation period, in which the stored settings are loaded into the receiver, and after that it settles in a running state. From the running state the host can freeze the receiver so that it can be reprogrammed. From the running state or the frozen state the host can put the receiver to sleep. Releasing the freeze always returns through initialisation. Waking from sleep always repeats the full startup period first.

A settling guard protects re-initialisation. Every accepted configuration write restarts a minimum-delay counter, whose length is derived from the clock frequency and a gap in microseconds. Initialisation is not entered until that counter has run out. The receiver core reads its settings through a registered read port.

Top module: `rx_mode_seq`

## Requirements
- R1: On reset, mode_state is 0 (startup), rf_enable is 1, and osc_low_prec, rx_freeze and cfg_load are 0. The state codes are: startup 0, init 1, run 2, frozen 3, sleep 4.
- R2: Startup lasts at least STARTUP_CYC cycles and init lasts exactly INIT_CYC cycles, after which the state becomes run. cfg_load is high for exactly the one cycle in which mode_state first shows init.
- R3: A frame is sent in SPI mode 0, MSB first, while spi_csn is low. It carries an operation byte, then an address byte, then a data byte. Its effect appears on the fourth rising clk edge after the first edge that samples spi_csn high.
- R4: A frame is dropped when spi_csn rises after any number of sclk rising edges other than 24.
- R5: Only the operation code 0x02 (write) has any effect. Frames with any other operation code change nothing.
- R6: Address 0x03 is the mode register. Data bit 6 requests freeze and data bit 5 requests sleep. In run, sleep takes priority over freeze. Mode writes during startup or init are ignored, so the frozen state is entered only from run.
- R7: While frozen, rx_freeze is 1. A mode write with both bit 5 and bit 6 clear arms the release, and the state then leaves frozen only for init. A mode write with bit 5 set leaves frozen for sleep instead.
- R8: Init is entered no earlier than DELAY_CYC+1 clock edges after the edge that accepted the last configuration write. This applies both to release from frozen and to wake-up from sleep. DELAY_CYC is CLK_MHZ*GAP_US.
- R9: A write to any address other than 0x03 is stored only while the state is frozen or sleep. In every other state it is discarded.
- R10: In sleep, rf_enable is 0 and osc_low_prec is 1. A mode write with bit 5 clear moves the state from sleep to startup.
- R11: cfg_rd_data returns the byte stored at cfg_rd_addr one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| cfg_rd_addr | input | ADDR_W | Configuration read address from the receiver core |
| cfg_rd_data | output | DATA_W | Registered configuration byte |
| mode_state | output | 3 | Current mode code (see R1) |
| rf_enable | output | 1 | RF section powered |
| osc_low_prec | output | 1 | Oscillator in low-precision mode |
| rx_freeze | output | 1 | Receiver frozen for reprogramming |
| cfg_load | output | 1 | One-cycle strobe on entry to init |

## Verification
The hardest case to reach is a freeze request that arrives while the machine is still in startup or init, because a frame takes far longer than init does. The stimulus gets there by starting a freeze frame immediately after reset; the startup period is longer than one frame, so that frame lands while the machine is still in startup. The second hard case is the race between the release write and the delay counter. To create it, a configuration write is followed directly by the release frame, so the release is armed while the counter is still running. The exact cycle of entry to init is then checked against the cycle that accepted the write.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [2:0] {
    MS_STARTUP = 3'd0,
    MS_INIT    = 3'd1,
    MS_RUN     = 3'd2,
    MS_HOLD    = 3'd3,
    MS_SLEEP   = 3'd4
  } mode_e;

  localparam int          OP_W      = 8;
  localparam logic [7:0]  WR_OP     = 8'h02;
  localparam int          MODE_ADDR = 3;
  localparam int          HOLD_BIT  = 6;
  localparam int          SLEEP_BIT = 5;
endpackage

// File: rtl/rms_sync.sv
module rms_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rms_spi_rx.sv
module rms_spi_rx
  import rms_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              frm_valid,
  output logic [OP_W-1:0]   frm_op,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data
);
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [2:0] raw_in, syn_out;
  logic       sclk_s, csn_s, mosi_s;
  logic       sclk_d, csn_d;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  assign raw_in = {spi_sclk, spi_csn, spi_mosi};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    rms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == 1)) u_sync (
      .clk(clk), .rst(rst), .d(raw_in[g]), .q(syn_out[g])
    );
  end

  assign sclk_s = syn_out[2];
  assign csn_s  = syn_out[1];
  assign mosi_s = syn_out[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      csn_d     <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      frm_valid <= 1'b0;
      frm_op    <= '0;
      frm_addr  <= '0;
      frm_data  <= '0;
    end else begin
      sclk_d    <= sclk_s;
      csn_d     <= csn_s;
      frm_valid <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
        if (!csn_d && bit_cnt == CNT_W'(FRAME_W)) begin
          frm_valid                    <= 1'b1;
          {frm_op, frm_addr, frm_data} <= shreg;
        end
      end else if (sclk_s && !sclk_d) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R4: a commit only ever follows a frame of exactly FRAME_W bits
  p_commit_len_r4: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> $past(bit_cnt) == CNT_W'(FRAME_W));
endmodule

// File: rtl/rms_cfg_ram.sv
module rms_cfg_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/rms_mode_fsm.sv
module rms_mode_fsm
  import rms_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STARTUP_CYC = 400,
  parameter int INIT_CYC    = 16,
  parameter int DELAY_CYC   = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [OP_W-1:0]   frm_op,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic              req_hold,
  input  logic              req_sleep,
  output logic              cfg_we,
  output logic [2:0]        mode_state,
  output logic              rf_enable,
  output logic              osc_low_prec,
  output logic              rx_freeze,
  output logic              cfg_load
);
  localparam int PH_MAX = (STARTUP_CYC > INIT_CYC) ? STARTUP_CYC : INIT_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int DLY_W  = $clog2(DELAY_CYC + 1);

  mode_e             state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              pend_q, pend_d;
  logic              is_wr, mode_wr;

  assign is_wr   = frm_valid && (frm_op == WR_OP);
  assign mode_wr = is_wr && (frm_addr == ADDR_W'(MODE_ADDR));
  assign cfg_we  = is_wr && !mode_wr &&
                   (state_q == MS_HOLD || state_q == MS_SLEEP);

  always_comb begin
    dly_d = cfg_we ? DLY_W'(DELAY_CYC) :
            (dly_q != '0) ? dly_q - 1'b1 : dly_q;
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    pend_d  = pend_q;
    case (state_q)
      MS_STARTUP: begin
        if (phase_q == PH_W'(STARTUP_CYC - 1)) begin
          if (dly_q == '0) begin
            state_d = MS_INIT;
            phase_d = '0;
          end
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      MS_INIT: begin
        if (phase_q == PH_W'(INIT_CYC - 1)) begin
          state_d = MS_RUN;
          phase_d = '0;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      MS_RUN: begin
        if (mode_wr && req_sleep) begin
          state_d = MS_SLEEP;
        end else if (mode_wr && req_hold) begin
          state_d = MS_HOLD;
          pend_d  = 1'b0;
        end
      end
      MS_HOLD: begin
        if (mode_wr && req_sleep) begin
          state_d = MS_SLEEP;
          pend_d  = 1'b0;
        end else begin
          if (mode_wr && !req_hold) pend_d = 1'b1;
          if (pend_q && dly_q == '0) begin
            state_d = MS_INIT;
            phase_d = '0;
            pend_d  = 1'b0;
          end
        end
      end
      MS_SLEEP: begin
        if (mode_wr && !req_sleep) begin
          state_d = MS_STARTUP;
          phase_d = '0;
        end
      end
      default: begin
        state_d = MS_STARTUP;
        phase_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= MS_STARTUP;
      phase_q      <= '0;
      dly_q        <= '0;
      pend_q       <= 1'b0;
      rf_enable    <= 1'b1;
      osc_low_prec <= 1'b0;
      rx_freeze    <= 1'b0;
      cfg_load     <= 1'b0;
    end else begin
      state_q      <= state_d;
      phase_q      <= phase_d;
      dly_q        <= dly_d;
      pend_q       <= pend_d;
      rf_enable    <= (state_d != MS_SLEEP);
      osc_low_prec <= (state_d == MS_SLEEP);
      rx_freeze    <= (state_d == MS_HOLD);
      cfg_load     <= (state_d == MS_INIT) && (state_q != MS_INIT);
    end
  end

  assign mode_state = state_q;

  // R6: the frozen state is only ever entered from run
  p_hold_from_run_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == MS_HOLD) |-> $past(state_q) == MS_RUN);

  // R7: leaving frozen goes to init or sleep only
  p_hold_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(state_q == MS_HOLD) |-> (state_q == MS_INIT || state_q == MS_SLEEP));

  // R8: init is never entered while the settling counter runs
  p_init_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == MS_INIT) |-> $past(dly_q) == '0);

  // R10: leaving sleep always restarts the startup period
  p_wake_startup_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(state_q == MS_SLEEP) |-> state_q == MS_STARTUP);

  // R2: the load strobe lasts a single cycle
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !cfg_load);
endmodule

// File: rtl/rx_mode_seq.sv
module rx_mode_seq
  import rms_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_MHZ     = 50,
  parameter int GAP_US      = 40,
  parameter int STARTUP_CYC = 400,
  parameter int INIT_CYC    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic [ADDR_W-1:0] cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rd_data,
  output logic [2:0]        mode_state,
  output logic              rf_enable,
  output logic              osc_low_prec,
  output logic              rx_freeze,
  output logic              cfg_load
);
  localparam int DELAY_CYC = CLK_MHZ * GAP_US;

  logic              frm_valid;
  logic [OP_W-1:0]   frm_op;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  logic              cfg_we;

  rms_spi_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_spi (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .frm_valid(frm_valid), .frm_op(frm_op), .frm_addr(frm_addr), .frm_data(frm_data)
  );

  rms_mode_fsm #(
    .ADDR_W(ADDR_W), .STARTUP_CYC(STARTUP_CYC),
    .INIT_CYC(INIT_CYC), .DELAY_CYC(DELAY_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .frm_valid(frm_valid), .frm_op(frm_op), .frm_addr(frm_addr),
    .req_hold(frm_data[HOLD_BIT]), .req_sleep(frm_data[SLEEP_BIT]),
    .cfg_we(cfg_we), .mode_state(mode_state),
    .rf_enable(rf_enable), .osc_low_prec(osc_low_prec),
    .rx_freeze(rx_freeze), .cfg_load(cfg_load)
  );

  rms_cfg_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(cfg_we), .wa(frm_addr), .wd(frm_data),
    .ra(cfg_rd_addr), .rd(cfg_rd_data)
  );
endmodule

// File: tb/test_rx_mode_seq.sv
module test_rx_mode_seq;
  localparam int S_CYC = 400;
  localparam int I_CYC = 16;
  localparam int D_CYC = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0;
  logic       spi_csn = 1'b1;
  logic       spi_mosi = 1'b0;
  logic [7:0] cfg_rd_addr = 8'h00;
  logic [7:0] cfg_rd_data;
  logic [2:0] mode_state;
  logic       rf_enable, osc_low_prec, rx_freeze, cfg_load;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  int          m_edge = 0;
  int          m_st = 0, m_ph = 0, m_dly = 0, m_pend = 0, m_load = 0;
  int          q_edge[$];
  logic [23:0] q_frm[$];
  logic [7:0]  m_mem[int];
  logic [23:0] f;
  int          last_act;

  rx_mode_seq #(.CLK_MHZ(50), .GAP_US(40), .STARTUP_CYC(S_CYC), .INIT_CYC(I_CYC))
  i_rx_mode_seq (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data), .mode_state(mode_state),
    .rf_enable(rf_enable), .osc_low_prec(osc_low_prec), .rx_freeze(rx_freeze),
    .cfg_load(cfg_load)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: one step per rising edge
  always @(posedge clk) begin
    int  old_dly, old_pend, prev;
    bit  have, wr, mw, acc;
    m_edge++;
    if (rst) begin
      m_st = 0; m_ph = 0; m_dly = 0; m_pend = 0; m_load = 0;
    end else begin
      have = 1'b0;
      if (q_edge.size() > 0 && q_edge[0] == m_edge) begin
        void'(q_edge.pop_front());
        f = q_frm.pop_front();
        have = 1'b1;
      end
      wr  = have && f[23:16] == 8'h02;
      mw  = wr && f[15:8] == 8'h03;
      acc = wr && !mw && (m_st == 3 || m_st == 4);
      old_dly = m_dly; old_pend = m_pend; prev = m_st;
      if (acc) begin m_mem[int'(f[15:8])] = f[7:0]; m_dly = D_CYC; end
      else if (m_dly > 0) m_dly--;
      case (m_st)
        0: if (m_ph == S_CYC - 1) begin
             if (old_dly == 0) begin m_st = 1; m_ph = 0; end
           end else m_ph++;
        1: if (m_ph == I_CYC - 1) begin m_st = 2; m_ph = 0; end else m_ph++;
        2: if (mw && f[5]) m_st = 4;
           else if (mw && f[6]) begin m_st = 3; m_pend = 0; end
        3: if (mw && f[5]) begin m_st = 4; m_pend = 0; end
           else begin
             if (mw && !f[6]) m_pend = 1;
             if (old_pend == 1 && old_dly == 0) begin m_st = 1; m_ph = 0; m_pend = 0; end
           end
        default: if (mw && !f[5]) begin m_st = 0; m_ph = 0; end
      endcase
      m_load = (m_st == 1 && prev != 1) ? 1 : 0;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    logic [6:0] act, exp;
    string tg;
    if (cmp_on) begin
      act = {mode_state, rf_enable, osc_low_prec, rx_freeze, cfg_load};
      exp = {3'(m_st), 1'(m_st != 4), 1'(m_st == 4), 1'(m_st == 3), 1'(m_load)};
      tg = (m_st == 3) ? "R7 per-cycle outputs" :
           (m_st == 4) ? "R10 per-cycle outputs" : "R2 per-cycle outputs";
      check(act == exp, tg, int'(act), int'(exp));
    end
  end

  task automatic spi_frame(input logic [23:0] fr, input int nbits);
    @(negedge clk) spi_csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = (b < 24) ? fr[23-b] : 1'b0;
      repeat (5) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (5) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_csn = 1'b1;
    if (nbits == 24) begin
      last_act = m_edge + 4;
      q_edge.push_back(last_act);
      q_frm.push_back(fr);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_state(input int s, input string tag);
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (mode_state == 3'(s)) return;
    end
    check(1'b0, tag, int'(mode_state), s);
  endtask

  task automatic read_cfg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk) cfg_rd_addr = a;
    @(negedge clk);
    check(cfg_rd_data == exp, tag, int'(cfg_rd_data), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset state
    check({mode_state, rf_enable, osc_low_prec, rx_freeze, cfg_load} == 7'b000_1000,
          "R1 reset outputs", int'({mode_state, rf_enable, osc_low_prec, rx_freeze, cfg_load}), 8);

    // R6 freeze request during startup is ignored
    spi_frame(24'h02_03_40, 24);
    check(mode_state == 3'd0, "R6 freeze ignored in startup", int'(mode_state), 0);
    wait_state(1, "R2 reach init");
    check(cfg_load == 1'b1, "R2 load strobe on init entry", int'(cfg_load), 1);
    @(negedge clk);
    check(cfg_load == 1'b0, "R2 load strobe single cycle", int'(cfg_load), 0);
    wait_state(2, "R2 reach run");
    check(rx_freeze == 1'b0, "R6 no freeze after ignored request", int'(rx_freeze), 0);

    // R3 freeze from run
    spi_frame(24'h02_03_40, 24);
    check(mode_state == 3'd3, "R3 R6 freeze entered from run", int'(mode_state), 3);
    check(rx_freeze == 1'b1, "R7 freeze flag", int'(rx_freeze), 1);

    // R9 writes while frozen are kept
    spi_frame(24'h02_10_11, 24);
    spi_frame(24'h02_11_22, 24);
    w = last_act;
    read_cfg(8'h10, 8'h11, "R9 R11 write kept while frozen");
    spi_frame(24'h02_03_00, 24);
    check(mode_state == 3'd3, "R8 release waits for delay", int'(mode_state), 3);
    wait_state(1, "R7 release to init");
    check(m_edge - w == D_CYC + 1, "R8 init edge after last write", m_edge - w, D_CYC + 1);
    wait_state(2, "R2 back to run");

    // R9 write in run discarded
    spi_frame(24'h02_10_AA, 24);
    read_cfg(8'h10, 8'h11, "R9 write discarded in run");
    read_cfg(8'h11, 8'h22, "R11 second byte readback");

    // R5 wrong operation code
    spi_frame(24'h03_03_40, 24);
    check(mode_state == 3'd2, "R5 non-write opcode ignored", int'(mode_state), 2);
    // R4 short and long frames
    spi_frame(24'h02_03_40, 23);
    check(mode_state == 3'd2, "R4 23-bit frame dropped", int'(mode_state), 2);
    spi_frame(24'h02_03_40, 25);
    check(mode_state == 3'd2, "R4 25-bit frame dropped", int'(mode_state), 2);

    // R10 sleep and wake
    spi_frame(24'h02_03_60, 24);
    check(mode_state == 3'd4, "R6 sleep wins over freeze", int'(mode_state), 4);
    check(rf_enable == 1'b0 && osc_low_prec == 1'b1, "R10 sleep outputs",
          int'({rf_enable, osc_low_prec}), 1);
    spi_frame(24'h02_12_5C, 24);
    w = last_act;
    spi_frame(24'h02_03_00, 24);
    check(mode_state == 3'd0, "R10 wake goes to startup", int'(mode_state), 0);
    wait_state(1, "R10 init after wake");
    check(m_edge - w == D_CYC + 1, "R8 wake init gated by delay", m_edge - w, D_CYC + 1);
    wait_state(2, "R2 run after wake");
    read_cfg(8'h12, 8'h5C, "R9 write kept in sleep");

    // R7 sleep straight from frozen
    spi_frame(24'h02_03_40, 24);
    check(mode_state == 3'd3, "R6 freeze again", int'(mode_state), 3);
    spi_frame(24'h02_03_20, 24);
    check(mode_state == 3'd4, "R7 frozen to sleep", int'(mode_state), 4);
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule